// File: doc/BRIEF.md
# Programmable Even Clock Post-Divider

This block derives a slower clock from a fast source clock. A 5-bit ratio field, held in an 8-bit register, selects the output rate. A nonzero field value N gives an output at the source frequency divided by 2×N, with a 50% duty cycle. A field value of zero bypasses the divider, so the output runs at the source frequency.

The register has a byte-wide port with separate read and write strobes. The register can be read at any time. A write is dropped while the `sys_sel` input is high, which marks that the divided clock is in use as the system clock.

Alongside the clock itself, the block drives a single-cycle enable, `tick`, in the source clock domain. It pulses once per output period, so logic that stays on the source clock can use it in place of the divided clock. A ratio change is applied only when an output period ends. The period in flight therefore always finishes at its old length, and no shortened pulse appears on the output.

Top module: `clk_postdiv`

## Requirements
- R1: The ratio field occupies bits 4:0 of the register. Bits 7:5 always read back as zero, whatever value was written to them.
- R2: With a nonzero field value N, `tick` pulses exactly once every 2×N source cycles.
- R3: With a field value of zero, `clk_out` follows `clk` (high after a rising edge, low after a falling edge) and `tick` is high on every cycle.
- R4: Reset sets the register to zero, so the block leaves reset in bypass with `tick` high every cycle.
- R5: While `rd_en` is high, `rdata` shows the register contents. While `rd_en` is low, `rdata` is zero.
- R6: A write issued while `sys_sel` is high leaves the register and the output period unchanged.
- R7: With a nonzero N, `clk_out` is low for N source cycles and then high for N source cycles in each period, starting low right after a `tick`.
- R8: A new ratio is applied only at the end of an output period. The period in progress when the write lands completes at the old length, and the following period uses the new length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_sel | input | 1 | High while the divided clock is in use; blocks register writes |
| wr_en | input | 1 | Write strobe for the ratio register |
| wdata | input | 8 | Write data; bits 4:0 carry the ratio |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Register contents while `rd_en` is high, else zero |
| clk_out | output | 1 | Divided clock, or `clk` itself in bypass |
| tick | output | 1 | One-cycle pulse at the end of each output period |

## Verification
The assertions check on every cycle that:
- the reserved read bits stay zero;
- a write blocked by `sys_sel` leaves the register unchanged;
- reset clears the ratio;
- the applied ratio changes only at a period boundary;
- the phase counter stays below the applied ratio.

Only the bench's scenarios can show the following, because they depend on measuring intervals between events:
- the actual output period for every ratio from 0 to 31;
- the low/high split of the divided clock;
- the old-then-new period lengths around a ratio change.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

    localparam int DIV_W  = 5;
    localparam int DATA_W = 8;

    typedef logic [DIV_W-1:0]  ratio_t;
    typedef logic [DATA_W-1:0] byte_t;

    // Running state of the divider
    typedef struct packed {
        ratio_t cnt;     // position inside the current half period
        logic   phase;   // 0: low half, 1: high half
        ratio_t applied; // ratio in use for the current period
    } div_state_t;

    function automatic logic half_done(input ratio_t cnt, input ratio_t ratio);
        return (ratio != '0) && (cnt == ratio - ratio_t'(1));
    endfunction

    function automatic byte_t pack_readback(input ratio_t r);
        return {{(DATA_W-DIV_W){1'b0}}, r};
    endfunction

endpackage

// File: rtl/pdiv_regif.sv
module pdiv_regif
    import pdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   lock,
    input  logic   wr_en,
    input  byte_t  wdata,
    input  logic   rd_en,
    output byte_t  rdata,
    output ratio_t ratio
);

    ratio_t field_q;

    always_ff @(posedge clk) begin
        if (rst)
            field_q <= '0;
        else if (wr_en && !lock)
            field_q <= wdata[DIV_W-1:0];
    end

    assign ratio = field_q;
    assign rdata = rd_en ? pack_readback(field_q) : '0;

    assert_write_lock_R6: assert property (@(posedge clk) disable iff (rst)
        (lock && wr_en) |=> $stable(field_q));

    assert_reset_clears_R4: assert property (@(posedge clk)
        rst |=> (field_q == '0));

endmodule

// File: rtl/pdiv_counter.sv
module pdiv_counter
    import pdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  ratio_t req_ratio,
    output logic   bypass,
    output logic   phase,
    output logic   tick
);

    div_state_t st_q, st_d;
    logic       last_half;
    logic       period_end;

    always_comb begin
        last_half  = half_done(st_q.cnt, st_q.applied);
        period_end = last_half && st_q.phase;
        st_d       = st_q;
        if (st_q.applied == '0) begin
            // bypass: every cycle is a boundary
            st_d.applied = req_ratio;
            st_d.cnt     = '0;
            st_d.phase   = 1'b0;
        end else if (last_half) begin
            st_d.cnt = '0;
            if (st_q.phase) begin
                st_d.phase   = 1'b0;
                st_d.applied = req_ratio;
            end else begin
                st_d.phase = 1'b1;
            end
        end else begin
            st_d.cnt = st_q.cnt + ratio_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign bypass = (st_q.applied == '0);
    assign phase  = st_q.phase;
    assign tick   = bypass || period_end;

    assert_ratio_at_boundary_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q.applied != '0 && !(st_q.phase && st_q.cnt == st_q.applied - ratio_t'(1)))
        |=> $stable(st_q.applied));

    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        (st_q.applied != '0) |-> (st_q.cnt < st_q.applied));

    assert_reset_bypass_R4: assert property (@(posedge clk)
        rst |=> (st_q.applied == '0 && !st_q.phase));

endmodule

// File: rtl/pdiv_outmux.sv
module pdiv_outmux (
    input  logic clk,
    input  logic bypass,
    input  logic phase,
    output logic clk_out
);

    assign clk_out = bypass ? clk : phase;

endmodule

// File: rtl/clk_postdiv.sv
module clk_postdiv
    import pdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sys_sel,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    input  logic       rd_en,
    output logic [7:0] rdata,
    output logic       clk_out,
    output logic       tick
);

    ratio_t ratio;
    logic   bypass;
    logic   phase;

    pdiv_regif u_regif (
        .clk   (clk),
        .rst   (rst),
        .lock  (sys_sel),
        .wr_en (wr_en),
        .wdata (wdata),
        .rd_en (rd_en),
        .rdata (rdata),
        .ratio (ratio)
    );

    pdiv_counter u_counter (
        .clk       (clk),
        .rst       (rst),
        .req_ratio (ratio),
        .bypass    (bypass),
        .phase     (phase),
        .tick      (tick)
    );

    pdiv_outmux u_outmux (
        .clk     (clk),
        .bypass  (bypass),
        .phase   (phase),
        .clk_out (clk_out)
    );

    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (rst)
        rdata[7:5] == 3'b000);

endmodule

// File: tb/tb_clk_postdiv.sv
`timescale 1ns/1ps
module tb_clk_postdiv;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sys_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic       clk_out;
    logic       tick;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    clk_postdiv dut (
        .clk(clk), .rst(rst), .sys_sel(sys_sel), .wr_en(wr_en), .wdata(wdata),
        .rd_en(rd_en), .rdata(rdata), .clk_out(clk_out), .tick(tick)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_reg(output int v);
        @(negedge clk);
        rd_en = 1'b1;
        #0.5;
        v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Called at a negedge where tick was seen; returns cycles to the next tick
    task automatic next_gap(output int gap);
        int start;
        start = cyc;
        do @(negedge clk); while (!tick);
        gap = cyc - start;
    endtask

    task automatic sync_tick();
        do @(negedge clk); while (!tick);
    endtask

    initial begin
        int v, g, highs;
        bit first_low;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R4: reset state
        read_reg(v);
        check("R4 reset value", v, 0);
        @(negedge clk);
        check("R4 bypass tick", tick, 1);
        // R5: read strobe low gives zero
        #0.5 check("R5 rdata idle", rdata, 0);

        // R1: reserved bits read zero
        write_reg(8'hFF);
        read_reg(v);
        check("R1 readback of 0xFF", v, 31);
        write_reg(8'hA6);
        read_reg(v);
        check("R1 readback of 0xA6", v, 6);
        check("R5 read returns field", v, 6);

        // Sweep all ratios: R2, R3, R7
        for (int n = 0; n < 32; n++) begin
            write_reg(8'(n));
            sync_tick(); next_gap(g); next_gap(g);
            next_gap(g);
            check(n == 0 ? "R3 bypass period" : "R2 period", g, n == 0 ? 1 : 2 * n);
            if (n == 0) begin
                @(posedge clk); #0.5;
                check("R3 clk_out high phase", clk_out, 1);
                @(negedge clk); #0.5;
                check("R3 clk_out low phase", clk_out, 0);
            end else begin
                highs = 0;
                first_low = 0;
                for (int k = 0; k < 2 * n; k++) begin
                    @(negedge clk);
                    if (k == 0) first_low = !clk_out;
                    if (clk_out) highs++;
                end
                check("R7 high cycles", highs, n);
                check("R7 starts low", first_low, 1);
            end
        end

        // R8: change ratio 3 -> 7 right at a tick
        write_reg(8'd3);
        sync_tick(); next_gap(g);
        wr_en = 1'b1; wdata = 8'd7;
        next_gap(g);
        wr_en = 1'b0;
        check("R8 in-flight period keeps old length", g, 6);
        next_gap(g);
        check("R8 following period uses new length", g, 14);

        // R6: writes blocked while selected
        sys_sel = 1'b1;
        write_reg(8'd9);
        read_reg(v);
        check("R6 register unchanged", v, 7);
        sync_tick(); next_gap(g); next_gap(g);
        check("R6 period unchanged", g, 14);
        sys_sel = 1'b0;
        write_reg(8'd2);
        read_reg(v);
        check("R6 write accepted after unlock", v, 2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule